// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block steps a 32-bit processor core out of reset. While reset is held it forces the status bits and the vector base to fixed values and clears the enables of the locally attached memories. Once reset is released it asks for the system bus. When the bus is granted and no other master holds it, the block reads two longwords. The first read fills the stack pointer and the second fills the program counter. After that it waits for the core to report that the first instruction has finished, then enters the running state with a one-cycle start pulse.

The block also owns the catastrophic halt. It enters the halt on an error in either vector read, on a misaligned program counter vector, on a fault before the first instruction completes, or on a fault raised while an exception is already being handled. Only reset leaves the halt. The states are RESET_HOLD, WAIT_GRANT, READ_SP, READ_PC, FETCH_FIRST, RUN and HALT. The transitions are:

- RESET_HOLD to WAIT_GRANT, always.
- WAIT_GRANT to READ_SP on a grant with no other master taking the bus.
- READ_SP to READ_PC on data-valid, or to HALT on error.
- READ_PC to FETCH_FIRST on aligned data-valid, or to HALT on error or misalignment.
- FETCH_FIRST to RUN on first-done, or to HALT on fault.
- RUN to HALT on a fault while an exception is active.
- Any state to RESET_HOLD while reset is low.

Top module: `boot_vector_seq`

## Requirements
- R1: A clock edge with `rst_n` low puts the block in RESET_HOLD whatever it was doing. After that edge `rd_req`, `bus_req`, `running`, `halted` and `start` are all 0, and an interrupted read is never resumed.
- R2: Under reset `sr_super` is 1, `sr_trace` is 0 and `sr_master` is 0.
- R3: Under reset the 3-bit `sr_ipl` mask is 7.
- R4: Under reset `vbr` is 0x00000000 and every bit of `mem_en` is 0.
- R5: `bus_req` is 1 in WAIT_GRANT, READ_SP and READ_PC. A read starts (`rd_req` rises) only after an edge where `bus_grant` is 1 and `bus_busy_other` is 0.
- R6: The first read uses address 0 and loads `sp` from `rd_data`. The second read uses address 4 and loads `pc`. A read completes on `rd_valid` or `rd_err`, with error taking priority. `rd_addr` does not change while a read is pending.
- R7: `rd_err` during either vector read moves the block to HALT at the next edge.
- R8: A program counter vector whose bits [1:0] are not 00 is an address error. The block moves to HALT and `pc` is not loaded, so `pc` is aligned whenever `running` is 1.
- R9: In FETCH_FIRST, `core_fault` leads to HALT. Otherwise `first_done` leads to RUN, and `start` is 1 for exactly the first RUN cycle.
- R10: In RUN, `core_fault` with `exc_active` leads to HALT. `core_fault` without `exc_active` has no effect on the state.
- R11: In HALT, no bus, fault or completion input has any effect. `halted` stays 1 and `rd_req` and `running` stay 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Bus granted to this core |
| bus_busy_other | input | 1 | Another master is taking the bus |
| bus_req | output | 1 | Bus ownership request |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Read data |
| rd_valid | input | 1 | Read data valid, completes the read |
| rd_err | input | 1 | Access error, completes the read |
| first_done | input | 1 | First instruction has completed |
| core_fault | input | 1 | Fault reported by the core |
| exc_active | input | 1 | Exception processing in progress |
| sr_super | output | 1 | Supervisor status bit |
| sr_trace | output | 1 | Trace status bit |
| sr_master | output | 1 | Master/interrupt-state status bit |
| sr_ipl | output | 3 | Interrupt priority mask |
| vbr | output | ADDR_W | Vector base |
| mem_en | output | NMEM | Local memory enables |
| sp | output | DATA_W | Initial stack pointer |
| pc | output | DATA_W | Initial program counter |
| start | output | 1 | One-cycle pulse on entry to RUN |
| running | output | 1 | Block is in RUN |
| halted | output | 1 | Block is in HALT |

## Verification
Each way into HALT can only be reached after a long preamble, and that makes them the hardest cases to reach from the ports. The bench must arbitrate for the bus, finish one or both vector reads and sometimes pass the first instruction before the fault can be injected. The bench therefore sweeps grant delay, read latency and a fault kind covering every halt path and the clean boot. It drives each run from reset through the whole handshake and then injects the fault at the one state where it applies. A separate pass pulls reset in the middle of the second read to show the read is abandoned.

// File: rtl/bvs_pkg.sv
package bvs_pkg;
    typedef enum logic [2:0] {
        ST_RESET_HOLD,
        ST_WAIT_GRANT,
        ST_READ_SP,
        ST_READ_PC,
        ST_FETCH_FIRST,
        ST_RUN,
        ST_HALT
    } bvs_state_e;

    localparam int IPL_W   = 3;
    localparam int IPL_TOP = (1 << IPL_W) - 1;
endpackage

// File: rtl/bvs_fsm.sv
module bvs_fsm
    import bvs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    input  logic              bus_busy_other,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  logic [1:0]        vec_low,
    input  logic              first_done,
    input  logic              core_fault,
    input  logic              exc_active,
    output logic              bus_req,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ld_sp,
    output logic              ld_pc,
    output logic              start,
    output logic              running,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] SP_ADDR = '0;
    localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(DATA_W / 8);

    bvs_state_e state, nxt;
    logic       start_q;
    logic       misaligned;

    assign misaligned = (vec_low != 2'b00);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET_HOLD:  nxt = ST_WAIT_GRANT;
            ST_WAIT_GRANT:  if (bus_grant && !bus_busy_other) nxt = ST_READ_SP;
            ST_READ_SP: begin
                if (rd_err)        nxt = ST_HALT;
                else if (rd_valid) nxt = ST_READ_PC;
            end
            ST_READ_PC: begin
                if (rd_err)        nxt = ST_HALT;
                else if (rd_valid) nxt = misaligned ? ST_HALT : ST_FETCH_FIRST;
            end
            ST_FETCH_FIRST: begin
                if (core_fault)      nxt = ST_HALT;
                else if (first_done) nxt = ST_RUN;
            end
            ST_RUN:         if (core_fault && exc_active) nxt = ST_HALT;
            ST_HALT:        nxt = ST_HALT;
            default:        nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RESET_HOLD;
            start_q <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= (nxt == ST_RUN) && (state != ST_RUN);
        end
    end

    always_comb begin
        bus_req = 1'b0;
        rd_req  = 1'b0;
        rd_addr = SP_ADDR;
        ld_sp   = 1'b0;
        ld_pc   = 1'b0;
        unique case (state)
            ST_WAIT_GRANT: bus_req = 1'b1;
            ST_READ_SP: begin
                bus_req = 1'b1;
                rd_req  = 1'b1;
                ld_sp   = rd_valid && !rd_err;
            end
            ST_READ_PC: begin
                bus_req = 1'b1;
                rd_req  = 1'b1;
                rd_addr = PC_ADDR;
                ld_pc   = rd_valid && !rd_err && !misaligned;
            end
            default: ;
        endcase
    end

    assign start   = start_q;
    assign running = (state == ST_RUN);
    assign halted  = (state == ST_HALT);
endmodule

// File: rtl/bvs_regs.sv
module bvs_regs
    import bvs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NMEM   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_sp,
    input  logic              ld_pc,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sr_super,
    output logic              sr_trace,
    output logic              sr_master,
    output logic [IPL_W-1:0]  sr_ipl,
    output logic [ADDR_W-1:0] vbr,
    output logic [NMEM-1:0]   mem_en,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_super  <= 1'b1;
            sr_trace  <= 1'b0;
            sr_master <= 1'b0;
            sr_ipl    <= IPL_W'(IPL_TOP);
            vbr       <= '0;
            sp        <= '0;
            pc        <= '0;
        end else begin
            if (ld_sp) sp <= rd_data;
            if (ld_pc) pc <= rd_data;
        end
    end

    for (genvar g = 0; g < NMEM; g++) begin : g_mem_en
        always_ff @(posedge clk) begin
            if (!rst_n) mem_en[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
    import bvs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NMEM   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    input  logic              bus_busy_other,
    output logic              bus_req,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  logic              first_done,
    input  logic              core_fault,
    input  logic              exc_active,
    output logic              sr_super,
    output logic              sr_trace,
    output logic              sr_master,
    output logic [2:0]        sr_ipl,
    output logic [ADDR_W-1:0] vbr,
    output logic [NMEM-1:0]   mem_en,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] pc,
    output logic              start,
    output logic              running,
    output logic              halted
);
    logic ld_sp, ld_pc;

    bvs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .bus_grant(bus_grant), .bus_busy_other(bus_busy_other),
        .rd_valid(rd_valid), .rd_err(rd_err), .vec_low(rd_data[1:0]),
        .first_done(first_done), .core_fault(core_fault), .exc_active(exc_active),
        .bus_req(bus_req), .rd_req(rd_req), .rd_addr(rd_addr),
        .ld_sp(ld_sp), .ld_pc(ld_pc),
        .start(start), .running(running), .halted(halted)
    );

    bvs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NMEM(NMEM)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ld_sp(ld_sp), .ld_pc(ld_pc), .rd_data(rd_data),
        .sr_super(sr_super), .sr_trace(sr_trace), .sr_master(sr_master),
        .sr_ipl(sr_ipl), .vbr(vbr), .mem_en(mem_en), .sp(sp), .pc(pc)
    );
endmodule

// File: rtl/bvs_checker.sv
module bvs_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_grant,
    input logic              bus_busy_other,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              rd_err,
    input logic [2:0]        sr_ipl,
    input logic [DATA_W-1:0] pc,
    input logic              start,
    input logic              running,
    input logic              halted
);
    a_r1_reset_aborts: assert property (@(posedge clk)
        !rst_n |=> (!rd_req && !running && !halted && !start));

    a_r3_ipl_top: assert property (@(posedge clk)
        !rst_n |=> (sr_ipl == 3'd7));

    a_r5_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> ($past(bus_grant) && !$past(bus_busy_other)));

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !rd_err) |=> (!rd_req || $stable(rd_addr)));

    a_r7_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_err) |=> halted);

    a_r8_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (pc[1:0] == 2'b00));

    a_r9_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> running);

    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !rd_req && !running));
endmodule

bind boot_vector_seq bvs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bvs_checker (
    .clk(clk), .rst_n(rst_n),
    .bus_grant(bus_grant), .bus_busy_other(bus_busy_other),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_err(rd_err),
    .sr_ipl(sr_ipl), .pc(pc), .start(start), .running(running), .halted(halted)
);

// File: tb/boot_vector_seq_bench.sv
module boot_vector_seq_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NM = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_grant = 1'b0, bus_busy_other = 1'b0;
    logic          bus_req, rd_req;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          rd_valid = 1'b0, rd_err = 1'b0;
    logic          first_done = 1'b0, core_fault = 1'b0, exc_active = 1'b0;
    logic          sr_super, sr_trace, sr_master;
    logic [2:0]    sr_ipl;
    logic [AW-1:0] vbr;
    logic [NM-1:0] mem_en;
    logic [DW-1:0] sp, pc;
    logic          start, running, halted;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    boot_vector_seq #(.ADDR_W(AW), .DATA_W(DW), .NMEM(NM)) u_boot_vector_seq (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_grant = 0; bus_busy_other = 0; rd_valid = 0; rd_err = 0;
        first_done = 0; core_fault = 0; exc_active = 0; rd_data = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        tick(); tick();
        chk("R1 rd_req", 32'(rd_req), 0);
        chk("R1 run/halt", {30'd0, running, halted}, 0);
        chk("R2 status bits", {29'd0, sr_super, sr_trace, sr_master}, 32'h4);
        chk("R3 ipl", 32'(sr_ipl), 7);
        chk("R4 vbr", vbr, 0);
        chk("R4 mem_en", 32'(mem_en), 0);
        rst_n = 1;
        tick();
        chk("R5 bus_req in wait", 32'(bus_req), 1);
        chk("R5 no read yet", 32'(rd_req), 0);
    endtask

    // one read: waits lat cycles then completes with data or error
    task automatic do_read(input logic [31:0] exp_addr, input int lat,
                           input bit err, input logic [31:0] data);
        chk("R6 rd_req", 32'(rd_req), 1);
        chk("R6 rd_addr", rd_addr, exp_addr);
        for (int i = 0; i < lat; i++) begin
            tick();
            chk("R6 addr held", rd_addr, exp_addr);
        end
        rd_data = data;
        rd_valid = !err;
        rd_err = err;
        tick();
        rd_valid = 0; rd_err = 0; rd_data = '0;
    endtask

    task automatic halt_sticky();
        bus_grant = 1; rd_valid = 1; first_done = 1; core_fault = 1; exc_active = 1;
        rd_data = 32'h100;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 halted", 32'(halted), 1);
            chk("R11 no read/run", {30'd0, rd_req, running}, 0);
        end
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        for (int gd = 0; gd < 3; gd++) begin
            for (int lat = 0; lat < 2; lat++) begin
                for (int kind = 0; kind < 7; kind++) begin
                    logic [31:0] spv, pcv;
                    spv = 32'h2000_0000 + 32'(gd * 4096 + lat * 256 + kind * 16);
                    pcv = 32'h0001_0000 + 32'(gd * 64 + lat * 32 + kind * 4)
                          + ((kind >= 2 && kind <= 4) ? 32'(kind - 1) : 32'd0);
                    do_reset();
                    // arbitration: grant blocked by another master, or no grant
                    for (int i = 0; i < gd; i++) begin
                        bus_grant = (i % 2 == 0);
                        bus_busy_other = 1;
                        tick();
                        chk("R5 held off", 32'(rd_req), 0);
                    end
                    bus_grant = 1; bus_busy_other = 0;
                    tick();
                    bus_grant = 0;
                    do_read(32'd0, lat, kind == 0, spv);
                    if (kind == 0) begin
                        chk("R7 sp err halts", 32'(halted), 1);
                        halt_sticky();
                        continue;
                    end
                    chk("R6 sp loaded", sp, spv);
                    do_read(32'd4, lat, kind == 1, pcv);
                    if (kind == 1) begin
                        chk("R7 pc err halts", 32'(halted), 1);
                        halt_sticky();
                        continue;
                    end
                    if (kind >= 2 && kind <= 4) begin
                        chk("R8 misaligned halts", 32'(halted), 1);
                        chk("R8 pc not loaded", pc, 0);
                        halt_sticky();
                        continue;
                    end
                    chk("R6 pc loaded", pc, pcv);
                    chk("R5 bus released", {30'd0, bus_req, rd_req}, 0);
                    chk("R9 not yet running", 32'(running), 0);
                    if (kind == 5) begin
                        core_fault = 1;
                        tick();
                        core_fault = 0;
                        chk("R9 early fault halts", 32'(halted), 1);
                        halt_sticky();
                        continue;
                    end
                    first_done = 1;
                    tick();
                    first_done = 0;
                    chk("R9 running", 32'(running), 1);
                    chk("R9 start pulse", 32'(start), 1);
                    tick();
                    chk("R9 start ends", 32'(start), 0);
                    core_fault = 1; exc_active = 0;
                    tick();
                    chk("R10 lone fault ignored", {30'd0, running, halted}, 32'h2);
                    core_fault = 0; exc_active = 1;
                    tick();
                    chk("R10 lone exc ignored", 32'(running), 1);
                    core_fault = 1; exc_active = 1;
                    tick();
                    idle_inputs();
                    chk("R10 fault on fault", {30'd0, running, halted}, 32'h1);
                    halt_sticky();
                end
            end
        end
        // reset pulled in the middle of the second read
        do_reset();
        bus_grant = 1;
        tick();
        bus_grant = 0;
        do_read(32'd0, 0, 0, 32'h3000_0000);
        chk("R6 second read pending", rd_addr, 4);
        rst_n = 0;
        tick();
        chk("R1 read aborted", {30'd0, rd_req, bus_req}, 0);
        rst_n = 1;
        rd_valid = 1; rd_data = 32'h0000_0040;
        tick();
        rd_valid = 0;
        chk("R1 not resumed", pc, 0);
        chk("R1 back to wait", {30'd0, bus_req, rd_req}, 32'h2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule